// File: doc/BRIEF.md
# Compared-Pair Switch with Spare Promotion

This block sits behind a bank of N redundant modules that all compute the same word. Two of them form an active pair whose results are compared every cycle. When the two words match and neither member reports an error, the first member's word is forwarded with a valid flag. The other modules are spares: they keep running, but their words go nowhere. A spare can still be retired if it raises its error flag.

A mismatch between the pair members, or an error flag on either of them, starts a one-cycle reconfiguration. The output is marked invalid for that cycle. Every module that raised its error flag is retired for good. If the words differ and neither pair member raised an error, the faulty member cannot be identified, so both are retired and a sticky ambiguity flag is set.

From the next clock edge, the pair is made up of the two lowest-indexed modules that are still healthy. A lower index means a higher priority. When fewer than two healthy modules remain, the block reports exhaustion and no longer marks any output valid.

Top module: `pas_switch`

## Requirements
- R1: While the pair's words are equal, neither pair member's error flag is high and the block is not exhausted, `out_valid` is 1 and `out_data` equals the word of module `sel_a`, in the same cycle.
- R2: In a cycle where the pair agrees and neither member's error flag is high, `sel_a` and `sel_b` keep their values across the next clock edge. This holds even when spares disagree or raise errors.
- R3: When the pair words differ and exactly one member's error flag is high, only that member is retired. From the next cycle the surviving member stays in the pair and the next healthy spare joins it.
- R4: The pair is always the two lowest-indexed healthy modules, and `sel_a` < `sel_b`. Module 0 has the highest priority.
- R5: A module whose error flag (bit i of `mod_err` for module i) is high on any clock edge out of reset is never selected again, even after the flag drops. This applies to spares too.
- R6: In the cycle where a pair member raises an error or the pair words differ, `reconfig` is 1 and `out_valid` is 0. The new pair is in use from the following cycle.
- R7: When the pair words differ and neither member's error flag is high, both members are retired. `ambiguous` becomes 1 from the next cycle and stays 1 until reset.
- R8: When fewer than two healthy modules remain after a clock edge, `exhausted` is 1 from that edge onward. While `exhausted` is 1, `out_valid` and `reconfig` are 0 whatever the inputs are.
- R9: After a synchronous reset, all modules are healthy, `sel_a`=0, `sel_b`=1, and `exhausted` and `ambiguous` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_data | input | N*W | Module words; module i occupies bits [i*W +: W] |
| mod_err | input | N | Error report per module; bit i belongs to module i |
| out_data | output | W | Word of pair member `sel_a` |
| out_valid | output | 1 | Pair agrees, no reconfiguration and not exhausted |
| sel_a | output | $clog2(N) | Lower index of the active pair |
| sel_b | output | $clog2(N) | Higher index of the active pair |
| reconfig | output | 1 | Reconfiguration cycle in progress |
| exhausted | output | 1 | Fewer than two healthy modules remain |
| ambiguous | output | 1 | Sticky: a mismatch occurred with no member blaming itself |

## Verification
The bench raises an error on a spare while the pair agrees. A design that ignored spare errors would later promote that module, and a design that over-reacted would reconfigure needlessly. Both mismatch cases are exercised, one with the second member at fault and one with neither member blaming itself. A wrong design would retire the survivor, keep both members, or forget to set the ambiguity flag. The bench also retires three modules in one edge, to catch a design that reports a pair built from a retired module or still marks data valid once fewer than two healthy modules are left.

// File: rtl/pas_switch.sv
module pas_switch #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N*W-1:0]                 mod_data,
  input  logic [N-1:0]                   mod_err,
  output logic [W-1:0]                   out_data,
  output logic                           out_valid,
  output logic [((N>1)?$clog2(N):1)-1:0] sel_a,
  output logic [((N>1)?$clog2(N):1)-1:0] sel_b,
  output logic                           reconfig,
  output logic                           exhausted,
  output logic                           ambiguous
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1) + 1;

  logic [N-1:0]  healthy, healthy_n, pair_mask;
  logic [W-1:0]  da, db;
  logic          mism, pair_err, amb_now;
  logic [IW-1:0] na, nb;
  logic [CW-1:0] hcnt;

  assign da        = mod_data[sel_a*W +: W];
  assign db        = mod_data[sel_b*W +: W];
  assign mism      = !exhausted && (da != db);
  assign pair_err  = mod_err[sel_a] | mod_err[sel_b];
  assign amb_now   = mism && !pair_err;
  assign reconfig  = !exhausted && (mism || pair_err);
  assign out_valid = !exhausted && !reconfig;
  assign out_data  = da;
  assign pair_mask = (N'(1) << sel_a) | (N'(1) << sel_b);
  assign healthy_n = healthy & ~mod_err & ~(amb_now ? pair_mask : '0);

  always_comb begin
    na   = '0;
    nb   = '0;
    hcnt = '0;
    for (int i = 0; i < N; i++) begin
      if (healthy_n[i]) begin
        if (hcnt == '0)
          na = IW'(i);
        else if (hcnt == CW'(1))
          nb = IW'(i);
        hcnt = hcnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      healthy   <= '1;
      sel_a     <= '0;
      sel_b     <= IW'(1);
      exhausted <= 1'b0;
      ambiguous <= 1'b0;
    end else begin
      healthy   <= healthy_n;
      exhausted <= (hcnt < CW'(2));
      if (hcnt >= CW'(2)) begin
        sel_a <= na;
        sel_b <= nb;
      end
      if (amb_now)
        ambiguous <= 1'b1;
    end
  end
endmodule

// File: rtl/pas_switch_chk.sv
module pas_switch_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic [N*W-1:0]                 mod_data,
  input logic [N-1:0]                   mod_err,
  input logic [W-1:0]                   out_data,
  input logic                           out_valid,
  input logic [((N>1)?$clog2(N):1)-1:0] sel_a,
  input logic [((N>1)?$clog2(N):1)-1:0] sel_b,
  input logic                           reconfig,
  input logic                           exhausted,
  input logic                           ambiguous
);
  logic [N-1:0] seen_err;
  logic [W-1:0] wa, wb;
  assign wa = mod_data[sel_a*W +: W];
  assign wb = mod_data[sel_b*W +: W];

  always_ff @(posedge clk) begin
    if (rst) seen_err <= '0;
    else     seen_err <= seen_err | mod_err;
  end

  p_valid_word_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == wb && out_data == wa));

  p_hold_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (!exhausted && wa == wb && !mod_err[sel_a] && !mod_err[sel_b])
      |=> ($stable(sel_a) && $stable(sel_b)));

  p_pair_order_r4: assert property (@(posedge clk) disable iff (rst)
    !exhausted |-> (sel_a < sel_b));

  p_no_retired_r5: assert property (@(posedge clk) disable iff (rst)
    !exhausted |-> (!seen_err[sel_a] && !seen_err[sel_b]));

  p_reconf_blank_r6: assert property (@(posedge clk) disable iff (rst)
    reconfig |-> !out_valid);

  p_amb_set_r7: assert property (@(posedge clk) disable iff (rst)
    (!exhausted && wa != wb && !mod_err[sel_a] && !mod_err[sel_b]) |=> ambiguous);

  p_exh_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    exhausted |-> (!out_valid && !reconfig));
endmodule

bind pas_switch pas_switch_chk #(.N(N), .W(W)) chk (
  .clk(clk), .rst(rst), .mod_data(mod_data), .mod_err(mod_err),
  .out_data(out_data), .out_valid(out_valid), .sel_a(sel_a), .sel_b(sel_b),
  .reconfig(reconfig), .exhausted(exhausted), .ambiguous(ambiguous));

// File: tb/pas_switch_test.sv
`timescale 1ns/1ps
module pas_switch_test;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*W-1:0] mod_data = '0;
  logic [N-1:0]   mod_err = '0;
  logic [W-1:0]   out_data;
  logic           out_valid, reconfig, exhausted, ambiguous;
  logic [1:0]     sel_a, sel_b;
  int nchecks = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  pas_switch #(.N(N), .W(W)) uut (
    .clk(clk), .rst(rst), .mod_data(mod_data), .mod_err(mod_err),
    .out_data(out_data), .out_valid(out_valid), .sel_a(sel_a), .sel_b(sel_b),
    .reconfig(reconfig), .exhausted(exhausted), .ambiguous(ambiguous));

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] v0, v1, v2, v3, input logic [N-1:0] e);
    @(negedge clk);
    mod_data = {v3, v2, v1, v0};
    mod_err  = e;
    #0.5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    mod_data = '0;
    mod_err = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    step(8'h10, 8'h10, 8'h10, 8'h10, 4'b0000);
    chk("R9 sel_a", sel_a, 0);
    chk("R9 sel_b", sel_b, 1);
    chk("R9 exhausted", exhausted, 0);
    chk("R9 ambiguous", ambiguous, 0);
    chk("R9 reconfig", reconfig, 0);
  endtask

  task automatic t_agree();
    do_reset();
    step(8'h3C, 8'h3C, 8'h01, 8'h02, 4'b0000);
    chk("R1 valid", out_valid, 1);
    chk("R1 data", out_data, 8'h3C);
    step(8'hA5, 8'hA5, 8'h77, 8'h00, 4'b0000);
    chk("R1 data second pattern", out_data, 8'hA5);
    chk("R2 sel_a held", sel_a, 0);
    chk("R2 sel_b held", sel_b, 1);
    step(8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0000);
    chk("R1 zero word valid", out_valid, 1);
    chk("R2 sel_b still held", sel_b, 1);
  endtask

  task automatic t_spare_err();
    do_reset();
    step(8'h55, 8'h55, 8'h55, 8'h55, 4'b0100);
    chk("R2 spare error no reconfig", reconfig, 0);
    chk("R2 spare error valid", out_valid, 1);
    step(8'h55, 8'h55, 8'h55, 8'h55, 4'b0000);
    chk("R2 pair kept a", sel_a, 0);
    chk("R2 pair kept b", sel_b, 1);
    step(8'h11, 8'h22, 8'h22, 8'h22, 4'b0001);
    chk("R6 reconfig", reconfig, 1);
    chk("R6 valid low", out_valid, 0);
    step(8'h11, 8'h22, 8'h22, 8'h22, 4'b0000);
    chk("R5 skip retired spare a", sel_a, 1);
    chk("R5 skip retired spare b", sel_b, 3);
    chk("R3 valid after swap", out_valid, 1);
    chk("R3 data after swap", out_data, 8'h22);
  endtask

  task automatic t_replace_b();
    do_reset();
    step(8'h40, 8'h41, 8'h40, 8'h40, 4'b0010);
    chk("R6 reconfig on b fault", reconfig, 1);
    chk("R6 valid low on b fault", out_valid, 0);
    step(8'h40, 8'h41, 8'h40, 8'h40, 4'b0000);
    chk("R3 survivor a", sel_a, 0);
    chk("R3 spare joins b", sel_b, 2);
    chk("R4 valid", out_valid, 1);
    chk("R3 data", out_data, 8'h40);
    chk("R3 not ambiguous", ambiguous, 0);
  endtask

  task automatic t_ambiguous();
    do_reset();
    step(8'h01, 8'h02, 8'h09, 8'h09, 4'b0000);
    chk("R7 reconfig", reconfig, 1);
    chk("R7 flag not yet", ambiguous, 0);
    step(8'h01, 8'h02, 8'h09, 8'h09, 4'b0000);
    chk("R7 flag set", ambiguous, 1);
    chk("R7 both retired a", sel_a, 2);
    chk("R7 both retired b", sel_b, 3);
    chk("R7 valid", out_valid, 1);
    step(8'h01, 8'h02, 8'h09, 8'h09, 4'b0000);
    chk("R7 flag sticky", ambiguous, 1);
  endtask

  task automatic t_exhaust();
    do_reset();
    step(8'h66, 8'h66, 8'h66, 8'h66, 4'b1101);
    chk("R6 reconfig before exhaustion", reconfig, 1);
    chk("R8 not yet exhausted", exhausted, 0);
    step(8'h66, 8'h66, 8'h66, 8'h66, 4'b0000);
    chk("R8 exhausted", exhausted, 1);
    chk("R8 valid low", out_valid, 0);
    chk("R8 reconfig low", reconfig, 0);
    step(8'h01, 8'h02, 8'h03, 8'h04, 4'b0010);
    chk("R8 mismatch ignored valid", out_valid, 0);
    chk("R8 mismatch ignored reconfig", reconfig, 0);
    chk("R8 stays exhausted", exhausted, 1);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_agree();
    t_spare_err();
    t_replace_b();
    t_ambiguous();
    t_exhaust();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule